// File: doc/BRIEF.md
# Slave TDM Serial Audio Port

This block connects a chain of cascaded audio converters to a processing core over a four-wire time-division-multiplexed serial link. The converter at the head of the chain is the timing master. It drives the bit clock and an active-high frame sync, and the port never generates either one. The port samples both lines, together with the serial input, in its own system clock domain. It follows the bit-clock edges and counts the bit and slot positions inside each frame.

A frame is one phase made of NUM_SLOTS words of WORD_W bits, one word for each converter channel. The first data bit comes one bit clock after the frame-sync bit. On the receive side each word is collected MSB first and handed to the core right-justified in an OUT_W-bit bus, together with its slot number and a one-cycle strobe. On the transmit side the core keeps a one-word holding register filled. The port takes the held word at the start of each slot, reports which slot took it, and shifts it out MSB first. A missing word makes the slot go out as zeros and sets a sticky underrun flag. A frame sync that arrives too early is reported, and the port restarts at slot 0.

Top module: `tdm_serial_port`

## Requirements
- R1: A frame sync seen high at a falling bit-clock edge starts a frame. The next falling edge samples bit WORD_W-1 of slot 0, and the frame then holds exactly NUM_SLOTS consecutive words of WORD_W bits.
- R2: Receive bits are sampled at falling bit-clock edges, MSB first, with no companding.
- R3: A received word sits in bits WORD_W-1:0 of rx_data_o, and bits OUT_W-1:WORD_W are zero.
- R4: Each complete received word raises rx_valid_o for exactly one system clock, after its last bit has been sampled, with rx_slot_o giving its slot number (0 for the first word after the frame sync).
- R5: Transmit bits change after rising bit-clock edges, MSB first. The MSB of slot 0 is driven in the bit period after the frame-sync bit, so a receiver sampling on falling edges sees every word intact and in slot order.
- R6: sdout_o is low during every bit period in which no frame is in progress.
- R7: A frame sync seen before the last bit of the last slot pulses sync_err_o for one clock. The partly received word is dropped and never strobed. The next falling edge samples slot 0 of the new frame.
- R8: A frame sync seen on the same falling edge as the last bit of the last slot is not an error. That bit completes the frame and a new frame starts at once.
- R9: If the holding register is empty when a slot starts, the slot is sent as all zeros and tx_underrun_o goes high and stays high until reset. Otherwise the held word is sent and the register empties.
- R10: At each slot start, tx_take_o pulses for one clock and tx_take_slot_o shows that slot number until the next slot start. One tx_wr_i pulse fills the holding register.
- R11: While reset is asserted, sdout_o, rx_valid_o, rx_data_o, tx_take_o, tx_underrun_o and sync_err_o are all low.
- R12: Bit clocks that arrive after a frame has completed and before the next frame sync produce no rx_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Bit clock from the chain master |
| fsync_i | input | 1 | Active-high frame sync from the chain master |
| sdin_i | input | 1 | Serial receive data |
| sdout_o | output | 1 | Serial transmit data |
| rx_valid_o | output | 1 | One-cycle strobe for a received word |
| rx_data_o | output | OUT_W | Received word, right-justified, upper bits zero |
| rx_slot_o | output | SLOT_W | Slot number of the received word |
| tx_wr_i | input | 1 | Loads tx_wdata_i into the holding register |
| tx_wdata_i | input | WORD_W | Next word to transmit |
| tx_take_o | output | 1 | One-cycle strobe at each transmit slot start |
| tx_take_slot_o | output | SLOT_W | Slot number of the most recent slot start |
| tx_underrun_o | output | 1 | Sticky flag: a slot started with nothing held |
| sync_err_o | output | 1 | One-cycle strobe for an early frame sync |

## Verification
Frames that end with the next sync on their last data bit are mixed with frames separated by idle gaps. A design that treats the coinciding sync as an error, or that loses the last bit of the frame, fails there. An early sync in the middle of a slot checks that a partial word is never strobed and that the following words come back with slot numbers from 0. A design that keeps counting from the old position would report them shifted. The transmit holding register is also starved in the middle of a run. This shows whether zeros go out only for the empty slots, whether the underrun flag stays set after the words come back, and whether the word order stays aligned through the sync error. Idle bit clocks with changing data must produce neither strobes nor transmit activity.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

  // Bit-clock events decoded in the system clock domain.
  typedef struct packed {
    logic rise;   // bit clock went high in this cycle
    logic fall;   // bit clock went low in this cycle
    logic fs;     // frame sync, aligned with the edge flags
    logic din;    // serial input, aligned with the edge flags
  } line_evt_t;

  // Width of an index into n items, at least one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tdm_line_sync.sv
module tdm_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bclk_i,
  input  logic                    fsync_i,
  input  logic                    sdin_i,
  output tdm_port_pkg::line_evt_t evt_o
);

  // One extra stage on the clock line provides the previous value for edge detection.
  logic [SYNC_STAGES:0] bclk_q, bclk_d;
  logic [SYNC_STAGES:0] fs_q, fs_d;
  logic [SYNC_STAGES:0] din_q, din_d;

  always_comb begin
    bclk_d = {bclk_q[SYNC_STAGES-1:0], bclk_i};
    fs_d   = {fs_q[SYNC_STAGES-1:0], fsync_i};
    din_d  = {din_q[SYNC_STAGES-1:0], sdin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= '0;
      fs_q   <= '0;
      din_q  <= '0;
    end else begin
      bclk_q <= bclk_d;
      fs_q   <= fs_d;
      din_q  <= din_d;
    end
  end

  always_comb begin
    evt_o.rise = bclk_q[SYNC_STAGES-1] & ~bclk_q[SYNC_STAGES];
    evt_o.fall = ~bclk_q[SYNC_STAGES-1] & bclk_q[SYNC_STAGES];
    evt_o.fs   = fs_q[SYNC_STAGES-1];
    evt_o.din  = din_q[SYNC_STAGES-1];
  end

endmodule

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq #(
  parameter int NUM_SLOTS = 4,
  parameter int WORD_W    = 16,
  localparam int SLOT_W   = tdm_port_pkg::idx_w(NUM_SLOTS),
  localparam int BIT_W    = tdm_port_pkg::idx_w(WORD_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  tdm_port_pkg::line_evt_t evt_i,
  output logic                    samp_o,
  output logic                    done_o,
  output logic                    load_o,
  output logic                    shift_o,
  output logic                    idle_o,
  output logic [SLOT_W-1:0]       slot_o,
  output logic                    err_o
);

  logic              active_q, active_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              err_q, err_d;
  logic              last_bit, last_slot, frame_last, early_fs;

  always_comb begin
    last_bit   = (bit_q == BIT_W'(WORD_W - 1));
    last_slot  = (slot_q == SLOT_W'(NUM_SLOTS - 1));
    frame_last = active_q & last_bit & last_slot;
    early_fs   = evt_i.fall & evt_i.fs & active_q & ~frame_last;

    // Receive side acts on falling edges, transmit side on rising edges.
    samp_o  = evt_i.fall & active_q & ~early_fs;
    done_o  = samp_o & last_bit;
    load_o  = evt_i.rise & active_q & (bit_q == '0);
    shift_o = evt_i.rise & active_q & (bit_q != '0);
    idle_o  = evt_i.rise & ~active_q;

    active_d = active_q;
    slot_d   = slot_q;
    bit_d    = bit_q;
    if (evt_i.fs) begin
      active_d = 1'b1;
      slot_d   = '0;
      bit_d    = '0;
    end else if (active_q) begin
      if (last_bit) begin
        bit_d = '0;
        if (last_slot) begin
          active_d = 1'b0;
          slot_d   = '0;
        end else begin
          slot_d = slot_q + SLOT_W'(1);
        end
      end else begin
        bit_d = bit_q + BIT_W'(1);
      end
    end
    err_d = early_fs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      if (evt_i.fall) begin
        active_q <= active_d;
        slot_q   <= slot_d;
        bit_q    <= bit_d;
      end
      err_q <= err_d;
    end
  end

  assign slot_o = slot_q;
  assign err_o  = err_q;

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
  parameter int WORD_W = 16,
  parameter int OUT_W  = 24,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_i,
  input  logic              done_i,
  input  logic              din_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  data_o,
  output logic [SLOT_W-1:0] slot_o
);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [WORD_W-1:0] word_full;
  logic [OUT_W-1:0]  word_fill;
  logic [OUT_W-1:0]  data_q;
  logic [SLOT_W-1:0] slot_q;
  logic              valid_q;

  always_comb begin
    sh_d      = {sh_q[WORD_W-2:0], din_i};
    word_full = sh_d;
  end

  generate
    if (OUT_W > WORD_W) begin : g_pad
      assign word_fill = {{(OUT_W - WORD_W){1'b0}}, word_full};
    end else begin : g_flat
      assign word_fill = word_full;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      data_q  <= '0;
      slot_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (samp_i) sh_q <= sh_d;
      if (done_i) begin
        data_q <= word_fill;
        slot_q <= slot_i;
      end
      valid_q <= done_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign slot_o  = slot_q;

endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser #(
  parameter int WORD_W = 16,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              idle_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              sdout_o,
  output logic              take_o,
  output logic [SLOT_W-1:0] take_slot_o,
  output logic              underrun_o
);

  logic [WORD_W-1:0] hold_q, hold_d;
  logic              full_q, full_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              dout_q, dout_d;
  logic              under_q, under_d;
  logic              take_q;
  logic [SLOT_W-1:0] tslot_q;
  logic              bit_en;

  always_comb begin
    hold_d  = wr_i ? wdata_i : hold_q;
    full_d  = (full_q & ~load_i) | wr_i;
    sh_d    = sh_q;
    dout_d  = dout_q;
    under_d = under_q;
    bit_en  = load_i | shift_i | idle_i;
    if (load_i) begin
      if (full_q) begin
        dout_d = hold_q[WORD_W-1];
        sh_d   = {hold_q[WORD_W-2:0], 1'b0};
      end else begin
        dout_d  = 1'b0;
        sh_d    = '0;
        under_d = 1'b1;
      end
    end else if (shift_i) begin
      dout_d = sh_q[WORD_W-1];
      sh_d   = {sh_q[WORD_W-2:0], 1'b0};
    end else if (idle_i) begin
      dout_d = 1'b0;
      sh_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      full_q  <= 1'b0;
      sh_q    <= '0;
      dout_q  <= 1'b0;
      under_q <= 1'b0;
      take_q  <= 1'b0;
      tslot_q <= '0;
    end else begin
      if (wr_i) hold_q <= hold_d;
      full_q <= full_d;
      if (bit_en) begin
        sh_q   <= sh_d;
        dout_q <= dout_d;
      end
      if (load_i) begin
        under_q <= under_d;
        tslot_q <= slot_i;
      end
      take_q <= load_i;
    end
  end

  assign sdout_o     = dout_q;
  assign take_o      = take_q;
  assign take_slot_o = tslot_q;
  assign underrun_o  = under_q;

endmodule

// File: rtl/tdm_serial_port.sv
module tdm_serial_port #(
  parameter int NUM_SLOTS   = 4,
  parameter int WORD_W      = 16,
  parameter int OUT_W       = 24,
  parameter int SYNC_STAGES = 2,
  localparam int SLOT_W     = tdm_port_pkg::idx_w(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic              sdin_i,
  output logic              sdout_o,
  output logic              rx_valid_o,
  output logic [OUT_W-1:0]  rx_data_o,
  output logic [SLOT_W-1:0] rx_slot_o,
  input  logic              tx_wr_i,
  input  logic [WORD_W-1:0] tx_wdata_i,
  output logic              tx_take_o,
  output logic [SLOT_W-1:0] tx_take_slot_o,
  output logic              tx_underrun_o,
  output logic              sync_err_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q, rst_pipe_d;
  logic       rst_core_n;

  always_comb rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_core_n = rst_pipe_q[1];

  tdm_port_pkg::line_evt_t evt;
  logic              samp, done, load, shift, idle;
  logic [SLOT_W-1:0] cur_slot;

  tdm_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .bclk_i  (bclk_i),
    .fsync_i (fsync_i),
    .sdin_i  (sdin_i),
    .evt_o   (evt)
  );

  tdm_slot_seq #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(WORD_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .evt_i   (evt),
    .samp_o  (samp),
    .done_o  (done),
    .load_o  (load),
    .shift_o (shift),
    .idle_o  (idle),
    .slot_o  (cur_slot),
    .err_o   (sync_err_o)
  );

  tdm_rx_deser #(.WORD_W(WORD_W), .OUT_W(OUT_W), .SLOT_W(SLOT_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .samp_i  (samp),
    .done_i  (done),
    .din_i   (evt.din),
    .slot_i  (cur_slot),
    .valid_o (rx_valid_o),
    .data_o  (rx_data_o),
    .slot_o  (rx_slot_o)
  );

  tdm_tx_ser #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .load_i      (load),
    .shift_i     (shift),
    .idle_i      (idle),
    .slot_i      (cur_slot),
    .wr_i        (tx_wr_i),
    .wdata_i     (tx_wdata_i),
    .sdout_o     (sdout_o),
    .take_o      (tx_take_o),
    .take_slot_o (tx_take_slot_o),
    .underrun_o  (tx_underrun_o)
  );

endmodule

// File: rtl/tdm_serial_port_chk.sv
module tdm_serial_port_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int WORD_W    = 16,
  parameter int OUT_W     = 24,
  localparam int SLOT_W   = tdm_port_pkg::idx_w(NUM_SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid_o,
  input logic [OUT_W-1:0]  rx_data_o,
  input logic              tx_take_o,
  input logic              tx_underrun_o,
  input logic              sync_err_o
);

  assert_rx_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  assert_no_word_on_sync_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_o |-> !rx_valid_o);

  assert_sync_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_o |=> !sync_err_o);

  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun_o |=> tx_underrun_o);

  assert_underrun_at_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_underrun_o) |-> tx_take_o);

  assert_take_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take_o |=> !tx_take_o);

  generate
    if (OUT_W > WORD_W) begin : g_fill
      assert_rx_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (rx_data_o[OUT_W-1:WORD_W] == '0));
    end
  endgenerate

endmodule

bind tdm_serial_port tdm_serial_port_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .WORD_W    (WORD_W),
  .OUT_W     (OUT_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_valid_o    (rx_valid_o),
  .rx_data_o     (rx_data_o),
  .tx_take_o     (tx_take_o),
  .tx_underrun_o (tx_underrun_o),
  .sync_err_o    (sync_err_o)
);

// File: tb/tdm_serial_port_tb_top.sv
`timescale 1ns/1ps
module tdm_serial_port_tb_top;

  localparam int NS   = 4;
  localparam int WW   = 16;
  localparam int OW   = 24;
  localparam int SW   = 2;
  localparam int HALF = 8;

  // Each entry: {serial word sent, expected rx_data_o}.
  localparam logic [39:0] VECS [16] = '{
    {16'h8000, 24'h008000}, {16'h0001, 24'h000001}, {16'hFFFF, 24'h00FFFF}, {16'h0000, 24'h000000},
    {16'hA5A5, 24'h00A5A5}, {16'h5A5A, 24'h005A5A}, {16'h1234, 24'h001234}, {16'hFEDC, 24'h00FEDC},
    {16'h7FFF, 24'h007FFF}, {16'h8001, 24'h008001}, {16'h0F0F, 24'h000F0F}, {16'hF0F0, 24'h00F0F0},
    {16'hC3C3, 24'h00C3C3}, {16'h3C3C, 24'h003C3C}, {16'h1111, 24'h001111}, {16'hEEEE, 24'h00EEEE}
  };

  logic          clk, rst_n, bclk, fsync, sdin, tx_wr;
  logic [WW-1:0] tx_wdata;
  logic          sdout, rx_valid, tx_take, tx_under, sync_err;
  logic [OW-1:0] rx_data;
  logic [SW-1:0] rx_slot, take_slot;

  int nchk = 0, nfail = 0;
  int rx_seen = 0, err_seen = 0;
  int wr_idx = 0, rd_idx = 0, tx_limit = 0;
  logic [OW-1:0] exp_data_q [$];
  logic [SW-1:0] exp_slot_q [$];

  tdm_serial_port dut_i (
    .clk (clk), .rst_n (rst_n), .bclk_i (bclk), .fsync_i (fsync), .sdin_i (sdin),
    .sdout_o (sdout), .rx_valid_o (rx_valid), .rx_data_o (rx_data), .rx_slot_o (rx_slot),
    .tx_wr_i (tx_wr), .tx_wdata_i (tx_wdata), .tx_take_o (tx_take),
    .tx_take_slot_o (take_slot), .tx_underrun_o (tx_under), .sync_err_o (sync_err)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  function automatic logic [WW-1:0] tx_word(input int i);
    return 16'hC0DE ^ WW'(i * 2341);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Receive monitor: compares every strobed word against the expected queue.
  initial forever begin
    @(negedge clk);
    if (rst_n && rx_valid) begin
      rx_seen++;
      if (exp_data_q.size() == 0) begin
        check(1'b0, "R12 R7 unexpected rx word", {6'b0, rx_slot, rx_data}, 32'h0);
      end else begin
        logic [OW-1:0] ed;
        logic [SW-1:0] es;
        ed = exp_data_q.pop_front();
        es = exp_slot_q.pop_front();
        check({rx_slot, rx_data} == {es, ed}, "R1 R2 R4 rx word/slot",
              {6'b0, rx_slot, rx_data}, {6'b0, es, ed});
        check(rx_data[OW-1:WW] == '0, "R3 zero fill", 32'(rx_data), 32'(ed));
      end
    end
    if (rst_n && sync_err) err_seen++;
  end

  // Transmit feeder: primes once, then refills the holding register after each take.
  initial begin
    tx_wr = 1'b0;
    tx_wdata = '0;
    forever begin
      @(negedge clk);
      tx_wr = 1'b0;
      if (rst_n && (tx_take || wr_idx == 0) && wr_idx < tx_limit) begin
        tx_wr = 1'b1;
        tx_wdata = tx_word(wr_idx);
        wr_idx++;
      end
    end
  end

  task automatic bit_cycle(input logic fs, input logic d, output logic so);
    @(negedge clk);
    bclk = 1'b1; fsync = fs; sdin = d;
    repeat (HALF - 1) @(negedge clk);
    so = sdout;
    @(negedge clk);
    bclk = 1'b0;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic idle_bits(input int n, input string req);
    logic so;
    for (int g = 0; g < n; g++) begin
      bit_cycle(1'b0, g[0], so);
      check(so == 1'b0, req, 32'(so), 32'h0);
    end
  endtask

  // Sends one frame. lead: send the frame-sync bit first. end_fs: raise the
  // sync on the last data bit. cut_at: stop after this many data bits (-1: none).
  task automatic run_frame(input logic [WW-1:0] w [NS], input logic [OW-1:0] e [NS],
                           input bit lead, input bit end_fs, input int cut_at);
    logic so;
    logic [WW-1:0] got, texp;
    if (lead) begin
      bit_cycle(1'b1, 1'b0, so);
    end
    for (int s = 0; s < NS; s++) begin
      if (cut_at < 0 || (s + 1) * WW <= cut_at) begin
        exp_data_q.push_back(e[s]);
        exp_slot_q.push_back(SW'(s));
      end
      got = '0;
      texp = '0;
      for (int b = 0; b < WW; b++) begin
        if (cut_at >= 0 && s * WW + b >= cut_at) return;
        if (b == 0) begin
          if (rd_idx < wr_idx) begin
            texp = tx_word(rd_idx);
            rd_idx++;
          end else begin
            texp = '0;
          end
        end
        bit_cycle(end_fs && s == NS - 1 && b == WW - 1, w[s][WW-1-b], so);
        got = {got[WW-2:0], so};
        if (b == 0) check(take_slot == SW'(s), "R10 take slot", 32'(take_slot), 32'(s));
      end
      check(got == texp, "R5 R9 tx word", 32'(got), 32'(texp));
    end
  endtask

  logic [WW-1:0] w [NS];
  logic [OW-1:0] e [NS];
  bit finished = 1'b0;

  task automatic make_frame(input logic [WW-1:0] base);
    for (int s = 0; s < NS; s++) begin
      w[s] = base + WW'(s * 16'h0111);
      e[s] = OW'(w[s]);
    end
  endtask

  initial begin
    bclk = 1'b0; fsync = 1'b0; sdin = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R11: outputs during reset
    check(sdout == 1'b0, "R11 sdout in reset", 32'(sdout), 0);
    check(rx_valid == 1'b0, "R11 rx_valid in reset", 32'(rx_valid), 0);
    check(rx_data == '0, "R11 rx_data in reset", 32'(rx_data), 0);
    check(tx_take == 1'b0, "R11 take in reset", 32'(tx_take), 0);
    check(tx_under == 1'b0, "R11 underrun in reset", 32'(tx_under), 0);
    check(sync_err == 1'b0, "R11 sync_err in reset", 32'(sync_err), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tx_limit = 1000;
    repeat (6) @(negedge clk);

    // Vector table: four frames, the middle ones chained back to back (R8).
    for (int f = 0; f < 4; f++) begin
      for (int s = 0; s < NS; s++) begin
        w[s] = VECS[f * NS + s][39:24];
        e[s] = VECS[f * NS + s][23:0];
      end
      run_frame(w, e, !(f == 2 || f == 3), (f == 1 || f == 2), -1);
      if (!(f == 1 || f == 2)) idle_bits(f + 1, "R6 idle sdout low");
    end
    check(err_seen == 0, "R8 no error on back-to-back sync", 32'(err_seen), 0);
    check(tx_under == 1'b0, "R9 no underrun while fed", 32'(tx_under), 0);

    // R12: bit clocks with toggling data but no sync.
    begin
      int n0;
      n0 = rx_seen;
      idle_bits(20, "R6 sdout low without frame");
      check(rx_seen == n0, "R12 no words without frame", 32'(rx_seen), 32'(n0));
    end

    // R7: early sync in slot 1, bit 5; then a full frame from slot 0.
    make_frame(16'h2468);
    run_frame(w, e, 1'b1, 1'b0, WW + 5);
    make_frame(16'h9ABC);
    run_frame(w, e, 1'b1, 1'b0, -1);
    idle_bits(2, "R6 idle sdout low");
    check(err_seen == 1, "R7 one sync error", 32'(err_seen), 1);
    check(exp_data_q.size() == 0, "R7 words after restart", 32'(exp_data_q.size()), 0);

    // R9: starve the holding register, then resume feeding.
    tx_limit = wr_idx;
    make_frame(16'h1357);
    run_frame(w, e, 1'b1, 1'b0, -1);
    idle_bits(2, "R6 idle sdout low");
    check(tx_under == 1'b1, "R9 underrun set", 32'(tx_under), 1);
    tx_limit = 1000;
    make_frame(16'h0BAD);
    run_frame(w, e, 1'b1, 1'b0, -1);
    idle_bits(2, "R6 idle sdout low");
    check(tx_under == 1'b1, "R9 underrun sticky", 32'(tx_under), 1);

    repeat (10) @(negedge clk);
    check(exp_data_q.size() == 0, "R4 all words delivered", 32'(exp_data_q.size()), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog expired", 0, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule